// File: doc/BRIEF.md
# Exception Entry Unit: Vector and Machine-State Rewrite

This block decides which pending exception a small RISC core takes on a clock edge. It forms the handler fetch address and computes the machine state register (MSR) value the handler starts with. In the same cycle it captures the interrupted MSR and instruction address into save registers.

Three reset sources cannot be masked, and they outrank every other request: hard reset, soft reset and the internal power-on event. The other eight causes arrive on a one-hot request vector. Two of those causes are gated by the external-interrupt enable bit of the current MSR. The pipeline samples the unit's registered outputs in the cycle after the request, when the taken strobe is high.

A parameter selects a reduced variant that has no floating-point state bits. In that variant those bits always read as zero.

Top module: `exc_entry`

## Requirements
- R1: While the reset input rst_n is low, taken is 0 and vec_addr, new_msr, saved_msr and ret_addr are all 0.
- R2: A hard reset request or a power-on request gives vec_addr 0xFFF0_0100 whatever cur_msr holds. It also gives a new_msr with only bit 6 (IP) set.
- R3: A soft reset request gives vec_addr = base + 0x100. The base is 0xFFF0_0000 when cur_msr bit 6 (IP) is 1 and 0x0000_0000 when it is 0.
- R4: The exc_req bits map to causes and offsets as follows. Bit 0 is system management (0x1400). Bit 1 is instruction TLB miss (0x1000). Bit 2 is data TLB load miss (0x1100). Bit 3 is data TLB store miss (0x1200). Bit 4 is instruction breakpoint (0x1300). Bit 5 is decrementer (0x900). Bit 6 is system call (0xC00). Bit 7 is trace (0xD00). vec_addr is formed from the IP base as in R3, plus the offset of the accepted cause.
- R5: At most one cause is accepted per cycle. The order runs from highest to lowest: hard reset or power-on, then soft reset, then exc_req bit 0, then bit 1, and so on up to bit 7.
- R6: The decrementer (bit 5) and system management (bit 0) requests are accepted only while cur_msr bit 15 (EE) is 1. The other request bits are accepted regardless of EE.
- R7: On a soft reset or any exc_req cause, new_msr keeps ME (bit 12), ILE (bit 16) and IP (bit 6) from cur_msr. It sets LE (bit 0) equal to ILE and clears every other bit.
- R8: The three TLB-miss causes also set TGPR (bit 17) in new_msr.
- R9: On every accepted cause, saved_msr takes cur_msr and ret_addr takes cur_pc. Both are sampled at the accepting edge.
- R10: taken is 1 for exactly the cycle after each accepting edge. It is 0 after any edge at which nothing is accepted. The other outputs hold their values until the next accepted cause.
- R11: Only the mask 0x0007_FF73 of MSR bits is implemented. Reserved bits read as 0 in new_msr and saved_msr.
- R12: With REDUCED=1, FP (bit 13), FE0 (bit 11) and FE1 (bit 8) read as 0 in both new_msr and saved_msr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the unit |
| hard_rst_req | input | 1 | Hard reset exception request |
| soft_rst_req | input | 1 | Soft reset exception request |
| por_req | input | 1 | Internal power-on exception request |
| exc_req | input | 8 | One-hot requests for the other causes (layout in R4) |
| cur_msr | input | MSR_W | Current machine state register |
| cur_pc | input | ADDR_W | Address of the interrupted instruction |
| taken | output | 1 | One-cycle strobe: an exception was accepted |
| vec_addr | output | ADDR_W | Handler fetch address |
| new_msr | output | MSR_W | MSR value for the handler |
| saved_msr | output | MSR_W | Saved copy of the interrupted MSR |
| ret_addr | output | ADDR_W | Saved return address |

## Verification
The properties assume the reset requests and exc_req are synchronous to clk and stable around the capturing edge. They also assume cur_msr and cur_pc are valid in the same cycle as the requests. The bench changes every input on the falling edge and usually holds a request for a single cycle. This lets the one-cycle strobe rule be observed. It samples the registered outputs on the next falling edge. Several causes are raised together on purpose, to exercise the priority order, and EE is toggled under the gated causes.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam int EXC_N = 8;

   // request vector positions, highest priority first
   localparam int RQ_SMI   = 0;
   localparam int RQ_ITLB  = 1;
   localparam int RQ_DTLBL = 2;
   localparam int RQ_DTLBS = 3;
   localparam int RQ_IABR  = 4;
   localparam int RQ_DEC   = 5;
   localparam int RQ_SC    = 6;
   localparam int RQ_TRACE = 7;

   // MSR bit positions (bit 0 is least significant)
   localparam int MB_LE   = 0;
   localparam int MB_RI   = 1;
   localparam int MB_DR   = 4;
   localparam int MB_IR   = 5;
   localparam int MB_IP   = 6;
   localparam int MB_FE1  = 8;
   localparam int MB_BE   = 9;
   localparam int MB_SE   = 10;
   localparam int MB_FE0  = 11;
   localparam int MB_ME   = 12;
   localparam int MB_FP   = 13;
   localparam int MB_PR   = 14;
   localparam int MB_EE   = 15;
   localparam int MB_ILE  = 16;
   localparam int MB_TGPR = 17;
   localparam int MB_POW  = 18;

   localparam logic [19:0] RESET_OFS = 20'h00100;

   function automatic logic [19:0] cause_offset(input int idx);
      case (idx)
         RQ_SMI:   return 20'h01400;
         RQ_ITLB:  return 20'h01000;
         RQ_DTLBL: return 20'h01100;
         RQ_DTLBS: return 20'h01200;
         RQ_IABR:  return 20'h01300;
         RQ_DEC:   return 20'h00900;
         RQ_SC:    return 20'h00C00;
         default:  return 20'h00D00;
      endcase
   endfunction

   function automatic logic [31:0] impl_mask(input bit reduced);
      logic [31:0] m;
      m = '0;
      m[MB_LE] = 1'b1;  m[MB_RI] = 1'b1;  m[MB_DR] = 1'b1;  m[MB_IR] = 1'b1;
      m[MB_IP] = 1'b1;  m[MB_BE] = 1'b1;  m[MB_SE] = 1'b1;  m[MB_ME] = 1'b1;
      m[MB_PR] = 1'b1;  m[MB_EE] = 1'b1;  m[MB_ILE] = 1'b1; m[MB_TGPR] = 1'b1;
      m[MB_POW] = 1'b1;
      m[MB_FP]  = !reduced;
      m[MB_FE0] = !reduced;
      m[MB_FE1] = !reduced;
      return m;
   endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_entry_pkg::*;
#(
   parameter int N = EXC_N,
   parameter logic [N-1:0] EE_GATED = N'(1 << RQ_SMI) | N'(1 << RQ_DEC)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hard_in,
   input  logic         soft_in,
   input  logic [N-1:0] req,
   input  logic         ee,
   output logic         hard_sel,
   output logic         soft_sel,
   output logic [N-1:0] grant,
   output logic         any_sel
);

   logic [N-1:0] qual;

   for (genvar i = 0; i < N; i++) begin : g_qual
      if (EE_GATED[i]) begin : g_gated
         assign qual[i] = req[i] & ee;
      end else begin : g_free
         assign qual[i] = req[i];
      end
   end

   assign hard_sel = hard_in;
   assign soft_sel = soft_in & ~hard_in;

   always_comb begin
      logic found;
      found = hard_in | soft_in;
      grant = '0;
      for (int i = 0; i < N; i++) begin
         if (qual[i] && !found) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   assign any_sel = hard_sel | soft_sel | (|grant);

   p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant, hard_sel, soft_sel}));

   p_ee_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant & EE_GATED)) |-> ee);

endmodule

// File: rtl/exc_vector.sv
module exc_vector
   import exc_entry_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int N = EXC_N,
   parameter logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(32'hFFF0_0000)
) (
   input  logic              hard_sel,
   input  logic              soft_sel,
   input  logic [N-1:0]      grant,
   input  logic              ip,
   output logic [ADDR_W-1:0] addr
);

   localparam int OFS_W = 20;

   logic [N-1:0][OFS_W-1:0] ofs_terms;
   logic [OFS_W-1:0]        ofs;
   logic [ADDR_W-1:0]       base;

   for (genvar i = 0; i < N; i++) begin : g_ofs
      assign ofs_terms[i] = grant[i] ? cause_offset(i) : '0;
   end

   always_comb begin
      ofs = soft_sel ? RESET_OFS : '0;
      for (int i = 0; i < N; i++) ofs |= ofs_terms[i];
   end

   assign base = (ip || hard_sel) ? HIGH_BASE : '0;
   assign addr = hard_sel ? (HIGH_BASE | ADDR_W'(RESET_OFS))
                          : (base | ADDR_W'(ofs));

endmodule

// File: rtl/exc_msr_next.sv
module exc_msr_next
   import exc_entry_pkg::*;
#(
   parameter int MSR_W = 32,
   parameter bit REDUCED = 1'b0
) (
   input  logic [MSR_W-1:0] cur_msr,
   input  logic             hard_sel,
   input  logic             tlb_sel,
   output logic [MSR_W-1:0] next_msr,
   output logic [MSR_W-1:0] clean_msr
);

   localparam logic [MSR_W-1:0] IMPL = MSR_W'(impl_mask(REDUCED));

   logic [MSR_W-1:0] kept;

   if (REDUCED) begin : g_lite
      assign clean_msr = cur_msr & IMPL;
   end else begin : g_full
      assign clean_msr = cur_msr & IMPL;
   end

   always_comb begin
      kept = '0;
      kept[MB_ME]  = clean_msr[MB_ME];
      kept[MB_ILE] = clean_msr[MB_ILE];
      kept[MB_IP]  = clean_msr[MB_IP];
      kept[MB_LE]  = clean_msr[MB_ILE];
      kept[MB_TGPR] = tlb_sel;
      if (hard_sel) begin
         next_msr = '0;
         next_msr[MB_IP] = 1'b1;
      end else begin
         next_msr = kept & IMPL;
      end
   end

endmodule

// File: rtl/exc_entry.sv
module exc_entry
   import exc_entry_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int MSR_W = 32,
   parameter bit REDUCED = 1'b0,
   parameter logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(32'hFFF0_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hard_rst_req,
   input  logic              soft_rst_req,
   input  logic              por_req,
   input  logic [EXC_N-1:0]  exc_req,
   input  logic [MSR_W-1:0]  cur_msr,
   input  logic [ADDR_W-1:0] cur_pc,
   output logic              taken,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [MSR_W-1:0]  new_msr,
   output logic [MSR_W-1:0]  saved_msr,
   output logic [ADDR_W-1:0] ret_addr
);

   localparam logic [MSR_W-1:0]  IMPL     = MSR_W'(impl_mask(REDUCED));
   localparam logic [ADDR_W-1:0] HARD_VEC = HIGH_BASE | ADDR_W'(RESET_OFS);

   if (ADDR_W < 21) begin : g_bad_addr
      $error("exc_entry: ADDR_W must be at least 21");
   end
   if (MSR_W < 19) begin : g_bad_msr
      $error("exc_entry: MSR_W must hold bit 18");
   end
   if (HIGH_BASE[19:0] != 20'h0) begin : g_bad_base
      $error("exc_entry: HIGH_BASE must be 1 MiB aligned");
   end

   logic              hard_sel, soft_sel, any_sel, tlb_sel;
   logic [EXC_N-1:0]  grant;
   logic [ADDR_W-1:0] vec_d;
   logic [MSR_W-1:0]  msr_d, clean_msr;

   exc_arbiter #(.N(EXC_N)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .hard_in  (hard_rst_req | por_req),
      .soft_in  (soft_rst_req),
      .req      (exc_req),
      .ee       (cur_msr[MB_EE]),
      .hard_sel (hard_sel),
      .soft_sel (soft_sel),
      .grant    (grant),
      .any_sel  (any_sel)
   );

   assign tlb_sel = grant[RQ_ITLB] | grant[RQ_DTLBL] | grant[RQ_DTLBS];

   exc_vector #(.ADDR_W(ADDR_W), .N(EXC_N), .HIGH_BASE(HIGH_BASE)) u_vec (
      .hard_sel (hard_sel),
      .soft_sel (soft_sel),
      .grant    (grant),
      .ip       (cur_msr[MB_IP]),
      .addr     (vec_d)
   );

   exc_msr_next #(.MSR_W(MSR_W), .REDUCED(REDUCED)) u_msr (
      .cur_msr   (cur_msr),
      .hard_sel  (hard_sel),
      .tlb_sel   (tlb_sel),
      .next_msr  (msr_d),
      .clean_msr (clean_msr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken     <= 1'b0;
         vec_addr  <= '0;
         new_msr   <= '0;
         saved_msr <= '0;
         ret_addr  <= '0;
      end else begin
         taken <= any_sel;
         if (any_sel) begin
            vec_addr  <= vec_d;
            new_msr   <= msr_d;
            saved_msr <= clean_msr;
            ret_addr  <= cur_pc;
         end
      end
   end

   p_hard_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hard_rst_req || por_req) |=> (taken && vec_addr == HARD_VEC));

   p_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
      any_sel |=> (saved_msr == $past(cur_msr & IMPL) && ret_addr == $past(cur_pc)));

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !any_sel |=> !taken);

   p_le_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> new_msr[MB_LE] == new_msr[MB_ILE]);

   p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> ((new_msr & ~IMPL) == '0 && (saved_msr & ~IMPL) == '0));

   if (REDUCED) begin : g_lite_chk
      p_no_fp_r12: assert property (@(posedge clk) disable iff (!rst_n)
         !(new_msr[MB_FP] || saved_msr[MB_FP] || saved_msr[MB_FE0] || saved_msr[MB_FE1]));
   end

endmodule

// File: tb/exc_entry_bench.sv
module exc_entry_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hard_rst_req = 1'b0, soft_rst_req = 1'b0, por_req = 1'b0;
   logic [7:0]  exc_req = '0;
   logic [31:0] cur_msr = '0, cur_pc = '0;
   logic        taken, taken_l;
   logic [31:0] vec_addr, new_msr, saved_msr, ret_addr;
   logic [31:0] vec_addr_l, new_msr_l, saved_msr_l, ret_addr_l;

   int n_tests = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_entry u_exc_entry (
      .clk(clk), .rst_n(rst_n), .hard_rst_req(hard_rst_req), .soft_rst_req(soft_rst_req),
      .por_req(por_req), .exc_req(exc_req), .cur_msr(cur_msr), .cur_pc(cur_pc),
      .taken(taken), .vec_addr(vec_addr), .new_msr(new_msr),
      .saved_msr(saved_msr), .ret_addr(ret_addr));

   exc_entry #(.REDUCED(1'b1)) u_exc_entry_lite (
      .clk(clk), .rst_n(rst_n), .hard_rst_req(hard_rst_req), .soft_rst_req(soft_rst_req),
      .por_req(por_req), .exc_req(exc_req), .cur_msr(cur_msr), .cur_pc(cur_pc),
      .taken(taken_l), .vec_addr(vec_addr_l), .new_msr(new_msr_l),
      .saved_msr(saved_msr_l), .ret_addr(ret_addr_l));

   localparam logic [31:0] FULL_MASK = 32'h0007_FF73;
   localparam logic [31:0] LITE_MASK = 32'h0007_D673;

   function automatic logic [31:0] ofs_of(input int i);
      logic [31:0] t [8] = '{32'h1400, 32'h1000, 32'h1100, 32'h1200,
                             32'h1300, 32'h0900, 32'h0C00, 32'h0D00};
      return t[i];
   endfunction

   // kind: 0 plain, 1 TLB miss
   function automatic logic [31:0] exp_msr(input int kind, input logic [31:0] m);
      logic [31:0] r;
      r = m & 32'h0001_1040;
      r[0] = m[16];
      if (kind == 1) r[17] = 1'b1;
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // raise inputs for one edge, sample on the next falling edge
   task automatic fire(input logic h, input logic s, input logic p,
                       input logic [7:0] rq, input logic [31:0] m, input logic [31:0] pc);
      @(negedge clk);
      hard_rst_req = h; soft_rst_req = s; por_req = p;
      exc_req = rq; cur_msr = m; cur_pc = pc;
      @(negedge clk);
      hard_rst_req = 0; soft_rst_req = 0; por_req = 0; exc_req = '0;
      cur_msr = 32'h5A5A_5A5A; cur_pc = 32'hDEAD_0000;
   endtask

   task automatic t_reset;
      check("R1 taken", {31'b0, taken}, 0);
      check("R1 vec", vec_addr, 0);
      check("R1 new_msr", new_msr, 0);
      check("R1 saved", saved_msr, 0);
      check("R1 ret", ret_addr, 0);
   endtask

   task automatic t_hard;
      fire(1, 0, 0, 8'h00, 32'hFFFF_FFBF, 32'h100);
      check("R2 hard taken", {31'b0, taken}, 1);
      check("R2 hard vec", vec_addr, 32'hFFF0_0100);
      check("R2 hard msr", new_msr, 32'h40);
      fire(0, 0, 1, 8'h00, 32'h0, 32'h104);
      check("R2 por vec", vec_addr, 32'hFFF0_0100);
      check("R2 por msr", new_msr, 32'h40);
   endtask

   task automatic t_soft;
      fire(0, 1, 0, 8'h00, 32'h0001_F000, 32'h200);
      check("R3 soft ip0 vec", vec_addr, 32'h0000_0100);
      check("R7 soft msr", new_msr, exp_msr(0, 32'h0001_F000));
      fire(0, 1, 0, 8'h00, 32'h0000_0040, 32'h204);
      check("R3 soft ip1 vec", vec_addr, 32'hFFF0_0100);
   endtask

   task automatic t_offsets;
      for (int ip = 0; ip < 2; ip++) begin
         for (int i = 0; i < 8; i++) begin
            logic [31:0] m;
            m = 32'h0001_9000 | (ip ? 32'h40 : 32'h0);
            fire(0, 0, 0, 8'(1 << i), m, 32'h1000 + 32'(i));
            check($sformatf("R4 vec cause %0d ip %0d", i, ip), vec_addr,
                  (ip ? 32'hFFF0_0000 : 32'h0) | ofs_of(i));
            check($sformatf("R7/R8 msr cause %0d", i), new_msr,
                  exp_msr((i >= 1 && i <= 3) ? 1 : 0, m));
         end
      end
   endtask

   task automatic t_priority;
      fire(1, 1, 0, 8'hFF, 32'h0000_8000, 32'h300);
      check("R5 hard over soft", vec_addr, 32'hFFF0_0100);
      check("R5 hard over soft msr", new_msr, 32'h40);
      fire(0, 1, 0, 8'hFF, 32'h0000_8000, 32'h304);
      check("R5 soft over causes", vec_addr, 32'h100);
      fire(0, 0, 0, 8'hA1, 32'h0000_8000, 32'h308);
      check("R5 smi over trace", vec_addr, 32'h1400);
      fire(0, 0, 0, 8'h2C, 32'h0000_8000, 32'h30C);
      check("R5 itlb-free: dtlb load first", vec_addr, 32'h1100);
   endtask

   task automatic t_gating;
      fire(0, 0, 0, 8'h21, 32'h0, 32'h400);
      check("R6 dec+smi masked, no taken", {31'b0, taken}, 0);
      check("R6 masked vec unchanged", vec_addr, 32'h1100);
      fire(0, 0, 0, 8'h61, 32'h0, 32'h404);
      check("R6 sc passes mask", vec_addr, 32'h0C00);
      fire(0, 0, 0, 8'h21, 32'h0000_8000, 32'h408);
      check("R6 smi with EE", vec_addr, 32'h1400);
   endtask

   task automatic t_save_pulse;
      fire(0, 0, 0, 8'h80, 32'hFFFF_FFFF, 32'hCAFE_0010);
      check("R9 saved", saved_msr, FULL_MASK);
      check("R9 ret", ret_addr, 32'hCAFE_0010);
      check("R11 new reserved", new_msr & ~FULL_MASK, 0);
      check("R12 lite saved", saved_msr_l, LITE_MASK);
      check("R12 lite new fp", new_msr_l & 32'h2900, 0);
      check("R10 taken high", {31'b0, taken}, 1);
      @(negedge clk);
      check("R10 taken drops", {31'b0, taken}, 0);
      check("R10 vec held", vec_addr, 32'hFFF0_0D00);
   endtask

   initial begin
      #(CLK_PERIOD * 3);
      t_reset;
      @(negedge clk) rst_n = 1'b1;
      t_hard;
      t_soft;
      t_offsets;
      t_priority;
      t_gating;
      t_save_pulse;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule